// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps two direction predictors side by side. The first is a per-address table of 2-bit saturating counters. The second is a table of 2-bit counters indexed by the branch address XOR a global outcome history. A third table of 2-bit counters, also indexed by address, decides for each branch which of the two predictors to trust. A lookup issued on the predict port returns, one cycle later, the final direction, the selector decision, both component directions and the history value the lookup used.

When a branch resolves, the caller presents the branch address, the real outcome, the two component directions it was given and the history snapshot it was given. Both component tables always train toward the outcome. The selector trains only when the two components disagreed. The resolved outcome is then shifted into the global history. The caller supplies the history snapshot on update, so training lands on the same shared-table entry that made the prediction, even if other branches have resolved in between.

Top module: `tourney_predictor`

## Requirements
- R1: After reset every counter in all three tables holds 1 (weakly not-taken / weakly prefer per-address), the global history is 0 and `pred_out_valid` is 0, so the first lookup returns taken=0, selector=0, both component bits 0 and history 0.
- R2: `pred_out_valid` is 1 in exactly the cycle after a cycle with `pred_valid` high, and 0 otherwise.
- R3: The per-address table entry is `pc[PC_ALIGN +: BIM_IDX_W]`, with no tag. `pred_bim_taken` is that counter's MSB, and the counter is updated on every `upd_valid`.
- R4: The shared-table entry is `pc[PC_ALIGN +: GSH_IDX_W]` XOR history. Lookups use the live history. Updates use `upd_hist`. `pred_gsh_taken` is that counter's MSB, and the counter is updated on every `upd_valid`.
- R5: Each `upd_valid` shifts the history left by one and places `upd_taken` in bit 0. With no update the history holds.
- R6: The selector entry is `pc[PC_ALIGN +: CHO_IDX_W]`. Selector MSB 1 gives `pred_used_gshare`=1 and `pred_taken`=`pred_gsh_taken`. MSB 0 gives `pred_used_gshare`=0 and `pred_taken`=`pred_bim_taken`.
- R7: The selector counter changes only when `upd_bim_taken` != `upd_gsh_taken`. It counts up if `upd_gsh_taken` == `upd_taken` and down otherwise.
- R8: Every counter increments on taken and decrements on not-taken, and stays at 3 or 0 at the ends.
- R9: A lookup and an update in the same cycle: the lookup sees the table contents and history from before that update.
- R10: `pred_hist` equals the global history as it was in the lookup cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pred_valid | input | 1 | Lookup request |
| pred_pc | input | PC_W | Branch address to look up |
| pred_out_valid | output | 1 | Lookup result valid |
| pred_taken | output | 1 | Final predicted direction |
| pred_used_gshare | output | 1 | 1 when the history-indexed component was chosen |
| pred_bim_taken | output | 1 | Per-address component direction |
| pred_gsh_taken | output | 1 | History-indexed component direction |
| pred_hist | output | HIST_W | History snapshot used by the lookup |
| upd_valid | input | 1 | Resolved branch strobe |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome |
| upd_bim_taken | input | 1 | Per-address direction given at lookup |
| upd_gsh_taken | input | 1 | History-indexed direction given at lookup |
| upd_hist | input | HIST_W | History snapshot given at lookup |

## Verification
The assertions assume that reset is applied for at least one clock edge. They also assume that the valid strobes and `upd_taken` are known 0/1 values whenever reset is low. They do not require the update port's claimed component bits or history to match an earlier lookup. Any values there are legal, and the bench relies on that by mixing faithful feedback with arbitrary claims. The stimulus holds both strobes low during reset and always drives every input to a defined value. Addresses come from a small pool so that table entries alias.

// File: rtl/tp_pkg.sv
package tp_pkg;
  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_WEAK_LOW = 2'd1;
  localparam ctr2_t CTR_MAX      = 2'd3;
  localparam ctr2_t CTR_MIN      = 2'd0;

  // saturating up/down step of a 2-bit counter
  function automatic ctr2_t ctr_step(input ctr2_t c, input logic up);
    ctr2_t n;
    if (up) n = (c == CTR_MAX) ? c : c + 2'd1;
    else    n = (c == CTR_MIN) ? c : c - 2'd1;
    return n;
  endfunction
endpackage

// File: rtl/tp_pc_index.sv
module tp_pc_index #(
  parameter int PC_W  = 32,
  parameter int ALIGN = 2,
  parameter int IDX_W = 6
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);
  logic unused_pc_bits;
  assign unused_pc_bits = ^pc;
  assign idx = pc[ALIGN +: IDX_W];
endmodule

// File: rtl/tp_gsh_hash.sv
module tp_gsh_hash #(
  parameter int PC_W   = 32,
  parameter int ALIGN  = 2,
  parameter int IDX_W  = 6,
  parameter int HIST_W = 6
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [HIST_W-1:0] hist,
  output logic [IDX_W-1:0]  idx
);
  logic [IDX_W-1:0] pc_part;
  logic [IDX_W-1:0] hist_part;

  tp_pc_index #(.PC_W(PC_W), .ALIGN(ALIGN), .IDX_W(IDX_W)) u_pc (
    .pc (pc),
    .idx(pc_part)
  );

  generate
    if (HIST_W <= IDX_W) begin : g_pad
      assign hist_part = IDX_W'(hist);
    end else begin : g_fold
      always_comb begin
        hist_part = '0;
        for (int i = 0; i < HIST_W; i++) begin
          hist_part[i % IDX_W] = hist_part[i % IDX_W] ^ hist[i];
        end
      end
    end
  endgenerate

  assign idx = pc_part ^ hist_part;
endmodule

// File: rtl/tp_ctr_table.sv
module tp_ctr_table #(
  parameter int            IDX_W = 6,
  parameter tp_pkg::ctr2_t INIT  = tp_pkg::CTR_WEAK_LOW
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  logic [IDX_W-1:0]     rd_idx,
  output tp_pkg::ctr2_t        rd_ctr,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic                 wr_up
);
  localparam int DEPTH = 1 << IDX_W;

  tp_pkg::ctr2_t mem [DEPTH];
  tp_pkg::ctr2_t rd_q;

  // read returns the pre-write contents on a same-cycle collision
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= INIT;
      rd_q <= INIT;
    end else begin
      if (wr_en) mem[wr_idx] <= tp_pkg::ctr_step(mem[wr_idx], wr_up);
      if (rd_en) rd_q <= mem[rd_idx];
    end
  end

  assign rd_ctr = rd_q;
endmodule

// File: rtl/tp_ghr.sv
module tp_ghr #(
  parameter int HIST_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist
);
  logic [HIST_W-1:0] hist_q;

  generate
    if (HIST_W == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst)           hist_q <= '0;
        else if (shift_en) hist_q <= bit_in;
      end
    end else begin : g_shift
      always_ff @(posedge clk) begin
        if (rst)           hist_q <= '0;
        else if (shift_en) hist_q <= {hist_q[HIST_W-2:0], bit_in};
      end
    end
  endgenerate

  assign hist = hist_q;
endmodule

// File: rtl/tourney_predictor.sv
module tourney_predictor #(
  parameter int PC_W      = 32,
  parameter int PC_ALIGN  = 2,
  parameter int BIM_IDX_W = 6,
  parameter int GSH_IDX_W = 6,
  parameter int CHO_IDX_W = 6,
  parameter int HIST_W    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pred_valid,
  input  logic [PC_W-1:0]   pred_pc,
  output logic              pred_out_valid,
  output logic              pred_taken,
  output logic              pred_used_gshare,
  output logic              pred_bim_taken,
  output logic              pred_gsh_taken,
  output logic [HIST_W-1:0] pred_hist,
  input  logic              upd_valid,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic              upd_taken,
  input  logic              upd_bim_taken,
  input  logic              upd_gsh_taken,
  input  logic [HIST_W-1:0] upd_hist
);
  logic [HIST_W-1:0]    hist_q;
  logic [BIM_IDX_W-1:0] bim_rd_idx, bim_wr_idx;
  logic [GSH_IDX_W-1:0] gsh_rd_idx, gsh_wr_idx;
  logic [CHO_IDX_W-1:0] cho_rd_idx, cho_wr_idx;
  tp_pkg::ctr2_t        bim_ctr, gsh_ctr, cho_ctr;
  logic                 out_valid_q;
  logic [HIST_W-1:0]    hist_snap_q;
  logic                 cho_train;
  logic                 cho_up;

  // index generation: lookup side uses live history, update side the snapshot
  tp_pc_index #(.PC_W(PC_W), .ALIGN(PC_ALIGN), .IDX_W(BIM_IDX_W)) u_bim_ri (
    .pc(pred_pc), .idx(bim_rd_idx));
  tp_pc_index #(.PC_W(PC_W), .ALIGN(PC_ALIGN), .IDX_W(BIM_IDX_W)) u_bim_wi (
    .pc(upd_pc), .idx(bim_wr_idx));
  tp_pc_index #(.PC_W(PC_W), .ALIGN(PC_ALIGN), .IDX_W(CHO_IDX_W)) u_cho_ri (
    .pc(pred_pc), .idx(cho_rd_idx));
  tp_pc_index #(.PC_W(PC_W), .ALIGN(PC_ALIGN), .IDX_W(CHO_IDX_W)) u_cho_wi (
    .pc(upd_pc), .idx(cho_wr_idx));
  tp_gsh_hash #(.PC_W(PC_W), .ALIGN(PC_ALIGN), .IDX_W(GSH_IDX_W), .HIST_W(HIST_W)) u_gsh_ri (
    .pc(pred_pc), .hist(hist_q), .idx(gsh_rd_idx));
  tp_gsh_hash #(.PC_W(PC_W), .ALIGN(PC_ALIGN), .IDX_W(GSH_IDX_W), .HIST_W(HIST_W)) u_gsh_wi (
    .pc(upd_pc), .hist(upd_hist), .idx(gsh_wr_idx));

  // selector trains only on disagreement, toward the side that was right
  assign cho_train = upd_valid && (upd_bim_taken != upd_gsh_taken);
  assign cho_up    = (upd_gsh_taken == upd_taken);

  tp_ctr_table #(.IDX_W(BIM_IDX_W), .INIT(tp_pkg::CTR_WEAK_LOW)) u_bim (
    .clk(clk), .rst(rst),
    .rd_en(pred_valid), .rd_idx(bim_rd_idx), .rd_ctr(bim_ctr),
    .wr_en(upd_valid), .wr_idx(bim_wr_idx), .wr_up(upd_taken));

  tp_ctr_table #(.IDX_W(GSH_IDX_W), .INIT(tp_pkg::CTR_WEAK_LOW)) u_gsh (
    .clk(clk), .rst(rst),
    .rd_en(pred_valid), .rd_idx(gsh_rd_idx), .rd_ctr(gsh_ctr),
    .wr_en(upd_valid), .wr_idx(gsh_wr_idx), .wr_up(upd_taken));

  tp_ctr_table #(.IDX_W(CHO_IDX_W), .INIT(tp_pkg::CTR_WEAK_LOW)) u_cho (
    .clk(clk), .rst(rst),
    .rd_en(pred_valid), .rd_idx(cho_rd_idx), .rd_ctr(cho_ctr),
    .wr_en(cho_train), .wr_idx(cho_wr_idx), .wr_up(cho_up));

  tp_ghr #(.HIST_W(HIST_W)) u_ghr (
    .clk(clk), .rst(rst),
    .shift_en(upd_valid), .bit_in(upd_taken), .hist(hist_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_q <= 1'b0;
      hist_snap_q <= '0;
    end else begin
      out_valid_q <= pred_valid;
      if (pred_valid) hist_snap_q <= hist_q;
    end
  end

  assign pred_out_valid   = out_valid_q;
  assign pred_bim_taken   = bim_ctr[1];
  assign pred_gsh_taken   = gsh_ctr[1];
  assign pred_used_gshare = cho_ctr[1];
  assign pred_taken       = cho_ctr[1] ? gsh_ctr[1] : bim_ctr[1];
  assign pred_hist        = hist_snap_q;
endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
  parameter int HIST_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              pred_valid,
  input logic              pred_out_valid,
  input logic              pred_taken,
  input logic              pred_used_gshare,
  input logic              pred_bim_taken,
  input logic              pred_gsh_taken,
  input logic [HIST_W-1:0] pred_hist,
  input logic              upd_valid,
  input logic              upd_taken,
  input logic [HIST_W-1:0] hist_q
);
  p_out_valid_r2: assert property (@(posedge clk) disable iff (rst)
    pred_valid |=> pred_out_valid);

  p_out_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !pred_valid |=> !pred_out_valid);

  p_select_r6: assert property (@(posedge clk) disable iff (rst)
    pred_out_valid |-> (pred_taken == (pred_used_gshare ? pred_gsh_taken : pred_bim_taken)));

  p_hist_in_r5: assert property (@(posedge clk) disable iff (rst)
    upd_valid |=> (hist_q[0] == $past(upd_taken)));

  p_hist_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> $stable(hist_q));

  p_snap_r10: assert property (@(posedge clk) disable iff (rst)
    pred_valid |=> (pred_hist == $past(hist_q)));
endmodule

bind tourney_predictor tp_checker #(.HIST_W(HIST_W)) u_tp_chk (
  .clk(clk), .rst(rst), .pred_valid(pred_valid), .pred_out_valid(pred_out_valid),
  .pred_taken(pred_taken), .pred_used_gshare(pred_used_gshare),
  .pred_bim_taken(pred_bim_taken), .pred_gsh_taken(pred_gsh_taken),
  .pred_hist(pred_hist), .upd_valid(upd_valid), .upd_taken(upd_taken),
  .hist_q(hist_q));

// File: tb/sim_tourney_predictor.sv
`timescale 1ns/1ps
module sim_tourney_predictor;
  logic        clk = 1'b0;
  logic        rst;
  logic        pred_valid;
  logic [31:0] pred_pc;
  logic        pred_out_valid, pred_taken, pred_used_gshare, pred_bim_taken, pred_gsh_taken;
  logic [5:0]  pred_hist;
  logic        upd_valid;
  logic [31:0] upd_pc;
  logic        upd_taken, upd_bim_taken, upd_gsh_taken;
  logic [5:0]  upd_hist;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  tourney_predictor u0 (
    .clk(clk), .rst(rst), .pred_valid(pred_valid), .pred_pc(pred_pc),
    .pred_out_valid(pred_out_valid), .pred_taken(pred_taken),
    .pred_used_gshare(pred_used_gshare), .pred_bim_taken(pred_bim_taken),
    .pred_gsh_taken(pred_gsh_taken), .pred_hist(pred_hist),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_bim_taken(upd_bim_taken), .upd_gsh_taken(upd_gsh_taken), .upd_hist(upd_hist));

  // reference model
  int unsigned m_bim [64];
  int unsigned m_gsh [64];
  int unsigned m_cho [64];
  logic [5:0]  m_hist;
  // last observed outputs, fed back on update
  logic l_bim, l_gsh;
  logic [5:0] l_hist;

  function automatic int unsigned step2(int unsigned c, bit up);
    if (up) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction
  function automatic int unsigned aidx(logic [31:0] pc);
    return int'(pc[7:2]);
  endfunction
  function automatic int unsigned hidx(logic [31:0] pc, logic [5:0] h);
    return int'(pc[7:2] ^ h);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycle(input bit pv, input logic [31:0] ppc,
                       input bit uv, input logic [31:0] upc, input bit ut,
                       input bit ub, input bit ug, input logic [5:0] uh);
    bit eb, eg, ec;
    logic [5:0] eh;
    @(negedge clk);
    pred_valid = pv; pred_pc = ppc;
    upd_valid = uv; upd_pc = upc; upd_taken = ut;
    upd_bim_taken = ub; upd_gsh_taken = ug; upd_hist = uh;
    // lookup sees state before the same-cycle update (R9)
    eb = m_bim[aidx(ppc)][1];
    eg = m_gsh[hidx(ppc, m_hist)][1];
    ec = m_cho[aidx(ppc)][1];
    eh = m_hist;
    if (uv) begin
      m_bim[aidx(upc)]    = step2(m_bim[aidx(upc)], ut);
      m_gsh[hidx(upc, uh)] = step2(m_gsh[hidx(upc, uh)], ut);
      if (ub != ug) m_cho[aidx(upc)] = step2(m_cho[aidx(upc)], ug == ut);
      m_hist = {m_hist[4:0], ut};
    end
    @(posedge clk); #1;
    chk("R2 out_valid", 32'(pred_out_valid), 32'(pv));
    if (pv) begin
      chk("R3 bimodal dir", 32'(pred_bim_taken), 32'(eb));
      chk("R4 shared dir", 32'(pred_gsh_taken), 32'(eg));
      chk("R6 selector", 32'(pred_used_gshare), 32'(ec));
      chk("R6 final dir", 32'(pred_taken), 32'(ec ? eg : eb));
      chk("R10 hist snapshot", 32'(pred_hist), 32'(eh));
      l_bim = pred_bim_taken; l_gsh = pred_gsh_taken; l_hist = pred_hist;
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 64; i++) begin m_bim[i] = 1; m_gsh[i] = 1; m_cho[i] = 1; end
    m_hist = '0;
    rst = 1'b1; pred_valid = 0; pred_pc = '0; upd_valid = 0; upd_pc = '0;
    upd_taken = 0; upd_bim_taken = 0; upd_gsh_taken = 0; upd_hist = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1 out_valid after reset", 32'(pred_out_valid), 32'd0);

    // R1: first lookup sees reset state
    cycle(1, 32'h100, 0, 0, 0, 0, 0, 0);
    chk("R1 taken", 32'(pred_taken), 0);
    chk("R1 selector", 32'(pred_used_gshare), 0);
    chk("R1 hist", 32'(pred_hist), 0);

    // R8: saturate upward, agreeing claims so the selector holds (R7)
    for (int k = 0; k < 4; k++) cycle(0, 0, 1, 32'h100, 1, 0, 0, 6'h0);
    cycle(1, 32'h100, 0, 0, 0, 0, 0, 0);
    chk("R8 saturated taken", 32'(pred_bim_taken), 1);
    chk("R5 hist after four taken", 32'(pred_hist), 32'h0f);
    cycle(0, 0, 1, 32'h100, 0, 1, 1, 6'h0);
    cycle(1, 32'h100, 0, 0, 0, 0, 0, 0);
    chk("R8 one not-taken from 3 stays taken", 32'(pred_bim_taken), 1);

    // R6/R7: disagreement with shared side right moves selector to shared
    cycle(0, 0, 1, 32'h100, 1, 0, 1, 6'h0);
    cycle(1, 32'h100, 0, 0, 0, 0, 0, 0);
    chk("R6 selects shared side", 32'(pred_used_gshare), 1);
    chk("R6 final follows shared side", 32'(pred_taken), 0);
    cycle(0, 0, 1, 32'h100, 0, 1, 1, 6'h0);
    cycle(1, 32'h100, 0, 0, 0, 0, 0, 0);
    chk("R7 agreement leaves selector", 32'(pred_used_gshare), 1);
    cycle(0, 0, 1, 32'h100, 0, 0, 1, 6'h0);
    cycle(1, 32'h100, 0, 0, 0, 0, 0, 0);
    chk("R7 shared wrong moves selector back", 32'(pred_used_gshare), 0);

    // R9: same-cycle lookup and update of one entry
    cycle(1, 32'h204, 1, 32'h204, 1, 0, 0, 6'h0);
    chk("R9 lookup sees old counter", 32'(pred_bim_taken), 0);
    cycle(1, 32'h204, 0, 0, 0, 0, 0, 0);
    chk("R9 next lookup sees new counter", 32'(pred_bim_taken), 1);

    // random traffic over an aliasing address pool
    for (int it = 0; it < 3000; it++) begin
      logic [31:0] pc, pc2;
      bit outc, conc, faithful;
      pc   = 32'h1000 + ((($urandom % 16) * 4) << ($urandom % 4));
      pc2  = 32'h2000 + (($urandom % 32) * 4);
      outc = (($urandom % 100) < ((pc[5:2] < 8) ? 85 : 25));
      conc = ($urandom % 3) == 0;
      faithful = ($urandom % 5) != 0;
      cycle(1, pc, 0, 0, 0, 0, 0, 0);
      if (faithful)
        cycle(conc, pc2, 1, pc, outc, l_bim, l_gsh, l_hist);
      else
        cycle(conc, pc2, 1, pc, outc, 1'($urandom), 1'($urandom), 6'($urandom));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule